// File: doc/BRIEF.md
# Sequential Sign-Magnitude Multiplier

This block multiplies two signed operands held in sign-magnitude form and returns a sign-magnitude product. The sign of the product is handled on its own path. A single bit compares the two operand signs, and only the magnitudes pass through an add-and-shift datapath. On each clock the datapath looks at one multiplier magnitude bit. When that bit is set, it adds the multiplicand magnitude into a running partial sum. It then shifts, so that every contribution ends up at its proper weight.

A client raises `start` together with the two operands while the unit is idle. The unit captures the operands, raises `busy`, and works for one cycle per magnitude bit. It then pulses `done` for a single cycle and presents the product. The product stays on the output until the next operation completes. A request made while the unit is busy is dropped.

Top module: `smul_seq`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is low is accepted at that clock edge, and `busy` reads 1 in the cycle that follows.
- R3: With OP_W = 8 there are 7 magnitude bits. `done` goes high exactly 7 clock edges after the accepting edge and stays high for one cycle only. `busy` falls at the same edge where `done` rises.
- R4: Each operand carries its sign in bit 7 and its magnitude in bits 6:0. The product's bits 14:0 hold the unsigned product of the two magnitudes.
- R5: When the magnitude is nonzero, product bit 15 is 1 if the two operand sign bits differ and 0 if they are equal.
- R6: A zero product magnitude is always reported with bit 15 = 0, whatever the operand signs are.
- R7: A `start` that arrives while `busy` is high is ignored. The running operation finishes on its original schedule with its original result.
- R8: `product` does not change except at the edge where `done` rises.
- R9: The operands are captured at the accepting edge. Later changes on `a_in` or `b_in` do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; taken only when idle |
| a_in | input | 8 | Multiplicand, sign in bit 7, magnitude in bits 6:0 |
| b_in | input | 8 | Multiplier, sign in bit 7, magnitude in bits 6:0 |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 16 | Sign in bit 15, magnitude in bits 14:0 |

## Verification
The assertions assume three things: `start` is a level that is sampled at the clock edge, the operands are stable at the edge where a request is accepted, and reset is asserted once before the first request. The bench changes inputs only on falling edges, so every sampled value is settled. It holds the operands steady across the accepting edge and then changes them deliberately during the run, so the bench checks capture directly, rather than the assertions assuming it. Requests issued while busy come from the same falling-edge driver. This means the ignore rule is checked against well-formed, edge-aligned stimulus only.

// File: rtl/smul_pkg.sv
package smul_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
   parameter int MAG_W = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic last,
   output logic busy
);
   import smul_pkg::*;
   localparam int CNT_W = $clog2(MAG_W + 1);

   smul_state_e state_q;
   logic [CNT_W-1:0] cnt_q;

   assign busy = (state_q == ST_RUN);
   assign load = start && (state_q == ST_IDLE);
   assign step = busy;
   assign last = step && (cnt_q == CNT_W'(MAG_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (load) begin
         state_q <= ST_RUN;
         cnt_q   <= '0;
      end else if (last) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (step) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/smul_dpath.sv
module smul_dpath #(
   parameter int MAG_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [MAG_W-1:0]   mcand_in,
   input  logic [MAG_W-1:0]   mplier_in,
   output logic [2*MAG_W-1:0] next_mag
);
   logic [MAG_W-1:0] mcand_q;
   logic [MAG_W-1:0] hi_q;
   logic [MAG_W-1:0] lo_q;
   logic [MAG_W-1:0] part;
   logic [MAG_W:0]   sum;

   // gate the multiplicand with the examined multiplier bit
   for (genvar i = 0; i < MAG_W; i++) begin : g_gate
      assign part[i] = mcand_q[i] & lo_q[0];
   end

   assign sum      = {1'b0, hi_q} + {1'b0, part};
   assign next_mag = {sum, lo_q[MAG_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else if (load) begin
         mcand_q <= mcand_in;
         hi_q    <= '0;
         lo_q    <= mplier_in;
      end else if (step) begin
         {hi_q, lo_q} <= next_mag;
      end
   end
endmodule

// File: rtl/smul_sign.sv
module smul_sign #(
   parameter int MAG_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               sign_a,
   input  logic               sign_b,
   input  logic [2*MAG_W-1:0] mag,
   output logic               neg
);
   logic differ_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    differ_q <= 1'b0;
      else if (load) differ_q <= sign_a ^ sign_b;
   end

   // a zero magnitude never carries a negative sign
   assign neg = differ_q && (|mag);
endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
   parameter int OP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   a_in,
   input  logic [OP_W-1:0]   b_in,
   output logic              busy,
   output logic              done,
   output logic [2*OP_W-1:0] product
);
   localparam int MAG_W = OP_W - 1;
   localparam int RES_W = 2 * OP_W;
   localparam int PAD   = RES_W - 1 - 2 * MAG_W;

   initial begin
      assert (OP_W >= 3) else $error("OP_W must be at least 3");
   end

   logic load, step, last, neg;
   logic [2*MAG_W-1:0] next_mag;
   logic [RES_W-1:0]   prod_q;
   logic               done_q;

   smul_ctrl #(.MAG_W(MAG_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .step(step), .last(last), .busy(busy)
   );

   smul_dpath #(.MAG_W(MAG_W)) u_dpath (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .mcand_in(a_in[MAG_W-1:0]), .mplier_in(b_in[MAG_W-1:0]),
      .next_mag(next_mag)
   );

   smul_sign #(.MAG_W(MAG_W)) u_sign (
      .clk(clk), .rst_n(rst_n), .load(load),
      .sign_a(a_in[OP_W-1]), .sign_b(b_in[OP_W-1]),
      .mag(next_mag), .neg(neg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= last;
         if (last) prod_q <= {neg, {PAD{1'b0}}, next_mag};
      end
   end

   assign product = prod_q;
   assign done    = done_q;
endmodule

// File: rtl/smul_seq_chk.sv
module smul_seq_chk #(
   parameter int OP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [OP_W-1:0]   a_in,
   input logic [OP_W-1:0]   b_in,
   input logic              busy,
   input logic              done,
   input logic [2*OP_W-1:0] product
);
   localparam int MAG_W = OP_W - 1;
   localparam int CW    = $clog2(MAG_W + 2) + 1;

   logic [CW-1:0] run_cnt;
   logic          exp_neg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         exp_neg <= 1'b0;
      end else if (start && !busy) begin
         run_cnt <= '0;
         exp_neg <= a_in[OP_W-1] ^ b_in[OP_W-1];
      end else if (busy) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == CW'(MAG_W) && !busy));
   // R5
   sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && product[2*OP_W-2:0] != '0) |-> (product[2*OP_W-1] == exp_neg));
   // R6
   no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (product[2*OP_W-2:0] == '0) |-> !product[2*OP_W-1]);
   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && run_cnt < CW'(MAG_W - 1)) |=> busy);
   // R8
   prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(done) |-> $stable(product));
endmodule

bind smul_seq smul_seq_chk #(.OP_W(OP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
   .busy(busy), .done(done), .product(product)
);

// File: tb/test_smul_seq.sv
module test_smul_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  a_in = '0;
   logic [7:0]  b_in = '0;
   logic        busy, done;
   logic [15:0] product;
   int compared = 0;
   int mismatched = 0;

   always #10 clk = ~clk;

   smul_seq i_smul_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .busy(busy), .done(done), .product(product)
   );

   function automatic logic [15:0] expect_of(input logic [7:0] a, input logic [7:0] b);
      logic [13:0] m;
      m = 14'(a[6:0]) * 14'(b[6:0]);
      return {(a[7] ^ b[7]) && (m != 0), 1'b0, m};
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic t_reset;
      check("R1 busy", 16'(busy), 16'd0);
      check("R1 done", 16'(done), 16'd0);
      check("R1 product", product, 16'd0);
   endtask

   // full run of one multiply; disturb=1 issues a start and changes operands mid-run
   task automatic t_mul(input logic [7:0] a, input logic [7:0] b, input bit disturb);
      logic [15:0] exp, prev;
      exp = expect_of(a, b);
      prev = product;
      @(negedge clk);
      a_in = a; b_in = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 busy", 16'(busy), 16'd1);
      for (int k = 2; k <= 7; k++) begin
         @(negedge clk);
         if (disturb && k == 3) begin
            start = 1'b1; a_in = ~a; b_in = ~b;   // R7 R9
         end else begin
            start = 1'b0;
         end
         check("R3 no early done", 16'(done), 16'd0);
         check("R8 hold", product, prev);
      end
      start = 1'b0;
      @(negedge clk);
      check("R3 done", 16'(done), 16'd1);
      check("R3 busy low", 16'(busy), 16'd0);
      check(disturb ? "R7 R9 result" : "R4 R5 R6 result", product, exp);
      @(negedge clk);
      check("R3 single pulse", 16'(done), 16'd0);
      check("R8 stable", product, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_mul(8'h03, 8'h05, 1'b0);   // R4 +3*+5 = 15
      t_mul(8'h87, 8'h09, 1'b0);   // R5 -7*+9 negative
      t_mul(8'h7F, 8'hFF, 1'b0);   // R4 R5 max magnitude, negative
      t_mul(8'h85, 8'h86, 1'b0);   // R5 equal signs, positive 30
      t_mul(8'h80, 8'h05, 1'b0);   // R6 -0 * +5 positive zero
      t_mul(8'h00, 8'h80, 1'b0);   // R6 +0 * -0
      t_mul(8'h8B, 8'h0D, 1'b1);   // R7 R9 disturbed run
      t_mul(8'h2A, 8'h81, 1'b0);   // back to back after disturbed run
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule